// File: doc/BRIEF.md
# Link Training Sequencer

This block is the source-side sequencer for two-phase serial link training. When it is started, it first switches the pattern off at the sink. It then runs a clock-recovery phase on pattern 1 and an equalization phase on pattern 2. In both phases it loops through the same steps: wait out a poll interval, ask for a status read, judge the returned done flags, and, if training is not yet done, turn the sink's adjust request into a new drive setting and write it out. When both phases have ended, it waits a settle time and switches the pattern off, at the sink first and then at the source. It then pulses `done`, reports a pass flag for each phase and keeps the last drive setting.

All work outside the block goes through one command channel to an AUX requester and the local transmitter. The block holds `cmd_req` with an operation code and a pattern number until it receives a one-cycle `cmd_ack`. For a status read, the ack arrives together with a success bit, the per-phase done flags from the field extractor, and the highest swing and emphasis levels that any lane requested. Every wait length is a parameter counted in clock cycles.

States: `S_IDLE`, `S_PRE_OFF`, `S_CR_PAT`, `S_CR_DRIVE0`, `S_CR_SETTLE`, `S_CR_WAIT`, `S_CR_READ`, `S_CR_DRIVE`, `S_EQ_PAT`, `S_EQ_WAIT`, `S_EQ_READ`, `S_EQ_DRIVE`, `S_END_SETTLE`, `S_END_SINK`, `S_END_SRC`, `S_DONE`.

Transitions:
- IDLE→PRE_OFF on `start`.
- Each command state moves on `cmd_ack`, in this order: PRE_OFF→CR_PAT→CR_DRIVE0→CR_SETTLE.
- CR_SETTLE→CR_WAIT and CR_WAIT→CR_READ when the timer expires.
- CR_READ→CR_DRIVE on a poll that is neither successful nor failing.
- CR_READ→EQ_PAT on pass or on failure.
- CR_DRIVE→CR_WAIT.
- EQ_PAT→EQ_WAIT, EQ_WAIT→EQ_READ.
- EQ_READ→EQ_DRIVE on a poll that is neither successful nor failing.
- EQ_READ→END_SETTLE on pass or on failure.
- EQ_DRIVE→EQ_WAIT.
- END_SETTLE→END_SINK→END_SRC→DONE→IDLE.

Top module: `lt_seq`

## Requirements
- R1: After reset, `cmd_req`, `done`, `cr_pass` and `eq_pass` are 0 and `train_set` is 0.
- R2: After `start`, the commands are issued in this order: op 0 (sink pattern) with pattern 0, then op 1 (pattern on source and sink) with pattern 1, then op 2 (drive write) with `train_set` equal to 0. The op codes are 0 sink pattern, 1 both-sides pattern, 2 drive write, 3 status read, 4 source pattern.
- R3: Once `cmd_req` is raised, it stays high with `cmd_op` and `cmd_pattern` unchanged until the cycle in which `cmd_ack` is 1.
- R4: Between the ack of the first drive write and the first status request, `cmd_req` is low for exactly SETTLE_CYC plus one poll interval.
- R5: The poll interval is POLL_SHORT_CYC cycles when `rd_interval` is 0, and POLL_UNIT_CYC×`rd_interval` otherwise. Every status request is preceded by this interval with `cmd_req` low. No other command is preceded by a gap, except the final sink pattern-off.
- R6: A status read acked with `cmd_ok`=0 ends the current phase as failed. Clock-recovery failure still continues into equalization.
- R7: A clock-recovery read with `rsp_cr_done`=1 sets `cr_pass` and moves to equalization, which issues op 1 with pattern 2.
- R8: After each poll that neither passes nor fails, `train_set` becomes {2'b00, emph==3, emph[1:0], swing==3, swing[1:0]} (bit 5 max emphasis, bits 4:3 emphasis, bit 2 max swing, bits 1:0 swing) from `rsp_emph`/`rsp_swing`. It is written with op 2 and holds its value after `done`.
- R9: A clock-recovery poll that is not done fails the phase if bit 2 of the current `train_set` is set.
- R10: Clock recovery counts consecutive polls in which swing bits 1:0 equal those of the previous poll, and a different swing resets the count to 0. The first poll never counts as a repeat. When the count reaches 5, the phase fails.
- R11: Equalization passes on `rsp_eq_done`=1. Its adjust counter starts at 0 and increments after each drive write. A poll that is not done fails the phase once the counter exceeds 5, which happens on the seventh read.
- R12: After equalization, the block waits SETTLE_CYC cycles and then issues op 0 with pattern 0, then op 4 with pattern 0. The cycle after the last ack, `done` pulses for one cycle with `cr_pass`/`eq_pass` valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a training run (used in idle) |
| rd_interval | input | 8 | Sink poll-interval setting |
| cmd_req | output | 1 | Command request, held until ack |
| cmd_op | output | 3 | Operation code of the request |
| cmd_pattern | output | 2 | Pattern number for pattern operations |
| cmd_ack | input | 1 | One-cycle completion of the current command |
| cmd_ok | input | 1 | Status read succeeded (valid with ack) |
| rsp_cr_done | input | 1 | All active lanes report clock recovered |
| rsp_eq_done | input | 1 | Lanes equalized and aligned |
| rsp_swing | input | 2 | Highest requested swing level |
| rsp_emph | input | 2 | Highest requested emphasis level |
| train_set | output | 8 | Current drive setting for all lanes |
| done | output | 1 | One-cycle end-of-run pulse |
| cr_pass | output | 1 | Clock-recovery phase succeeded |
| eq_pass | output | 1 | Equalization phase succeeded |

## Verification
A wrong state shows up at the ports within one command. A skipped or misordered state changes the next op code or pattern. A wrong timer or interval choice moves the next request by a measurable number of cycles. An attempt counter that is off by one changes how many status reads and drive writes a failing phase issues before the next pattern command. A bad adjust mapping appears on `train_set` at the next drive write. The bench compares every command, its setting and its preceding gap against a reference walk of the same response script.

// File: rtl/lt_pkg.sv
package lt_pkg;

    localparam int LVL_W = 2;
    localparam int SET_W = 8;

    typedef enum logic [2:0] {
        OP_SINK_PAT = 3'd0,
        OP_BOTH_PAT = 3'd1,
        OP_DRIVE    = 3'd2,
        OP_STATUS   = 3'd3,
        OP_SRC_PAT  = 3'd4
    } lt_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_PRE_OFF, S_CR_PAT, S_CR_DRIVE0, S_CR_SETTLE, S_CR_WAIT,
        S_CR_READ, S_CR_DRIVE, S_EQ_PAT, S_EQ_WAIT, S_EQ_READ, S_EQ_DRIVE,
        S_END_SETTLE, S_END_SINK, S_END_SRC, S_DONE
    } lt_state_e;

endpackage

// File: rtl/lt_timer.sv
module lt_timer #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          hit
);
    logic [TW-1:0] cnt;

    assign hit = run && (cnt >= limit - TW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || hit) cnt <= '0;
        else                       cnt <= cnt + TW'(1);
    end

    // R4: an idle timer always restarts from zero
    a_r4_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);

endmodule

// File: rtl/lt_adjust.sv
module lt_adjust
    import lt_pkg::*;
(
    input  logic [LVL_W-1:0] swing,
    input  logic [LVL_W-1:0] emph,
    output logic [SET_W-1:0] set_out
);
    localparam logic [LVL_W-1:0] TOP = '1;

    always_comb begin
        set_out       = '0;
        set_out[1:0]  = swing;
        set_out[2]    = (swing == TOP);
        set_out[4:3]  = emph;
        set_out[5]    = (emph == TOP);
    end

endmodule

// File: rtl/lt_repeat.sv
module lt_repeat
    import lt_pkg::*;
#(
    parameter int LIMIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [LVL_W-1:0] swing,
    output logic             exhausted
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW:0] LIM_V = (CW+1)'(LIMIT);

    logic [LVL_W:0] prev;
    logic [CW-1:0]  cnt;
    logic [CW:0]    cnt_inc;
    logic           same;

    assign same      = ({1'b0, swing} == prev);
    assign cnt_inc   = {1'b0, cnt} + (CW+1)'(1);
    assign exhausted = same && (cnt_inc >= LIM_V);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prev <= '1;
            cnt  <= '0;
        end else if (step) begin
            prev <= {1'b0, swing};
            cnt  <= same ? cnt_inc[CW-1:0] : '0;
        end
    end

    // R10: the repeat count never reaches the limit while the phase runs
    a_r10_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt} < LIM_V);

endmodule

// File: rtl/lt_seq.sv
module lt_seq
    import lt_pkg::*;
#(
    parameter int SETTLE_CYC      = 100000,
    parameter int POLL_SHORT_CYC  = 25000,
    parameter int POLL_UNIT_CYC   = 1000000,
    parameter int CR_REPEAT_LIMIT = 5,
    parameter int EQ_ADJ_LIMIT    = 5,
    parameter int TW              = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  rd_interval,
    output logic        cmd_req,
    output logic [2:0]  cmd_op,
    output logic [1:0]  cmd_pattern,
    input  logic        cmd_ack,
    input  logic        cmd_ok,
    input  logic        rsp_cr_done,
    input  logic        rsp_eq_done,
    input  logic [1:0]  rsp_swing,
    input  logic [1:0]  rsp_emph,
    output logic [7:0]  train_set,
    output logic        done,
    output logic        cr_pass,
    output logic        eq_pass
);
    localparam int EW = $clog2(EQ_ADJ_LIMIT + 2);

    lt_state_e        state, state_nx;
    lt_op_e           op;
    logic [EW-1:0]    eq_cnt;
    logic [SET_W-1:0] adj_set;
    logic [TW-1:0]    poll_lim, tmr_lim;
    logic             tmr_run, tmr_hit, rep_hit, rep_step;
    logic             cr_end, eq_end;

    assign poll_lim = (rd_interval == 8'd0) ? TW'(POLL_SHORT_CYC)
                                            : TW'(POLL_UNIT_CYC) * TW'(rd_interval);

    lt_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .limit(tmr_lim), .hit(tmr_hit)
    );

    lt_adjust u_adj (.swing(rsp_swing), .emph(rsp_emph), .set_out(adj_set));

    lt_repeat #(.LIMIT(CR_REPEAT_LIMIT)) u_rep (
        .clk(clk), .rst_n(rst_n), .clear(state == S_CR_PAT), .step(rep_step),
        .swing(train_set[1:0]), .exhausted(rep_hit)
    );

    assign cr_end   = !cmd_ok || rsp_cr_done || train_set[2] || rep_hit;
    assign eq_end   = !cmd_ok || rsp_eq_done || (eq_cnt > EW'(EQ_ADJ_LIMIT));
    assign rep_step = (state == S_CR_READ) && cmd_ack && !cr_end;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:       if (start)   state_nx = S_PRE_OFF;
            S_PRE_OFF:    if (cmd_ack) state_nx = S_CR_PAT;
            S_CR_PAT:     if (cmd_ack) state_nx = S_CR_DRIVE0;
            S_CR_DRIVE0:  if (cmd_ack) state_nx = S_CR_SETTLE;
            S_CR_SETTLE:  if (tmr_hit) state_nx = S_CR_WAIT;
            S_CR_WAIT:    if (tmr_hit) state_nx = S_CR_READ;
            S_CR_READ:    if (cmd_ack) state_nx = cr_end ? S_EQ_PAT : S_CR_DRIVE;
            S_CR_DRIVE:   if (cmd_ack) state_nx = S_CR_WAIT;
            S_EQ_PAT:     if (cmd_ack) state_nx = S_EQ_WAIT;
            S_EQ_WAIT:    if (tmr_hit) state_nx = S_EQ_READ;
            S_EQ_READ:    if (cmd_ack) state_nx = eq_end ? S_END_SETTLE : S_EQ_DRIVE;
            S_EQ_DRIVE:   if (cmd_ack) state_nx = S_EQ_WAIT;
            S_END_SETTLE: if (tmr_hit) state_nx = S_END_SINK;
            S_END_SINK:   if (cmd_ack) state_nx = S_END_SRC;
            S_END_SRC:    if (cmd_ack) state_nx = S_DONE;
            S_DONE:                    state_nx = S_IDLE;
            default:                   state_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            train_set <= '0;
            cr_pass   <= 1'b0;
            eq_pass   <= 1'b0;
            eq_cnt    <= '0;
        end else begin
            if (state == S_IDLE && start) begin
                cr_pass <= 1'b0;
                eq_pass <= 1'b0;
            end
            if (state == S_CR_PAT && cmd_ack) train_set <= '0;
            if (state == S_CR_READ && cmd_ack) begin
                if (cmd_ok && rsp_cr_done) cr_pass   <= 1'b1;
                else if (!cr_end)          train_set <= adj_set;
            end
            if (state == S_EQ_PAT) eq_cnt <= '0;
            if (state == S_EQ_READ && cmd_ack) begin
                if (cmd_ok && rsp_eq_done) eq_pass   <= 1'b1;
                else if (!eq_end)          train_set <= adj_set;
            end
            if (state == S_EQ_DRIVE && cmd_ack) eq_cnt <= eq_cnt + EW'(1);
        end
    end

    // outputs
    always_comb begin
        cmd_req     = 1'b0;
        op          = OP_SINK_PAT;
        cmd_pattern = 2'd0;
        tmr_run     = 1'b0;
        tmr_lim     = poll_lim;
        done        = 1'b0;
        unique case (state)
            S_PRE_OFF, S_END_SINK: begin cmd_req = 1'b1; op = OP_SINK_PAT; end
            S_CR_PAT:    begin cmd_req = 1'b1; op = OP_BOTH_PAT; cmd_pattern = 2'd1; end
            S_EQ_PAT:    begin cmd_req = 1'b1; op = OP_BOTH_PAT; cmd_pattern = 2'd2; end
            S_CR_DRIVE0, S_CR_DRIVE, S_EQ_DRIVE: begin cmd_req = 1'b1; op = OP_DRIVE; end
            S_CR_READ, S_EQ_READ: begin cmd_req = 1'b1; op = OP_STATUS; end
            S_END_SRC:   begin cmd_req = 1'b1; op = OP_SRC_PAT; end
            S_CR_SETTLE, S_END_SETTLE: begin tmr_run = 1'b1; tmr_lim = TW'(SETTLE_CYC); end
            S_CR_WAIT, S_EQ_WAIT: tmr_run = 1'b1;
            S_DONE:      done = 1'b1;
            default: ;
        endcase
    end

    assign cmd_op = op;

    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && !cmd_ack |=> cmd_req && $stable(cmd_op) && $stable(cmd_pattern));

    a_r2_start_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start) |=> cmd_req && cmd_op == 3'd0 && cmd_pattern == 2'd0);

    a_r12_done_after_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(cmd_ack) && $past(cmd_op) == 3'd4);

    a_r11_eq_bound: assert property (@(posedge clk) disable iff (!rst_n)
        eq_cnt <= EW'(EQ_ADJ_LIMIT + 1));

    a_r8_drive_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && cmd_op == 3'd2 |-> train_set[2] == (train_set[1:0] == 2'd3));

endmodule

// File: tb/lt_seq_test.sv
module lt_seq_test;
    localparam int SETTLE = 20;
    localparam int PSHORT = 6;
    localparam int PUNIT  = 8;
    localparam int SLEN   = 64;
    localparam int CMAX   = 256;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0] rd_interval = 8'd0;
    logic cmd_req, cmd_ack = 1'b0, cmd_ok = 1'b0, rsp_cr_done = 1'b0, rsp_eq_done = 1'b0;
    logic [2:0] cmd_op;
    logic [1:0] cmd_pattern, rsp_swing = 2'd0, rsp_emph = 2'd0;
    logic [7:0] train_set;
    logic done, cr_pass, eq_pass;

    always #2 clk = ~clk;

    lt_seq #(.SETTLE_CYC(SETTLE), .POLL_SHORT_CYC(PSHORT), .POLL_UNIT_CYC(PUNIT)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_interval(rd_interval),
        .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_pattern(cmd_pattern),
        .cmd_ack(cmd_ack), .cmd_ok(cmd_ok), .rsp_cr_done(rsp_cr_done),
        .rsp_eq_done(rsp_eq_done), .rsp_swing(rsp_swing), .rsp_emph(rsp_emph),
        .train_set(train_set), .done(done), .cr_pass(cr_pass), .eq_pass(eq_pass)
    );

    int checks = 0, failures = 0;

    // response script
    bit       sc_ok [SLEN];
    bit       sc_cr [SLEN];
    bit       sc_eq [SLEN];
    bit [1:0] sc_sw [SLEN];
    bit [1:0] sc_em [SLEN];
    int rd_idx = 0;

    // expected and observed commands
    int       exp_n, act_n = 0;
    int       exp_op [CMAX], exp_pat [CMAX], exp_gap [CMAX];
    bit [7:0] exp_ts [CMAX];
    string    exp_tag [CMAX];
    bit       exp_cr, exp_eq;
    bit [7:0] exp_final;
    int       act_op [CMAX], act_pat [CMAX], act_gap [CMAX];
    bit [7:0] act_ts [CMAX];
    int       gapcnt = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit [7:0] adj(input bit [1:0] s, input bit [1:0] e);
        return {2'b00, e == 2'd3, e, s == 2'd3, s};
    endfunction

    task automatic push(input int op, input int pat, input bit [7:0] ts,
                        input int gap, input string tag);
        exp_op[exp_n] = op; exp_pat[exp_n] = pat; exp_ts[exp_n] = ts;
        exp_gap[exp_n] = gap; exp_tag[exp_n] = tag; exp_n++;
    endtask

    // reference walk of the requirements over the script
    task automatic model(input int interval);
        int poll, prev, cnt, r, ecnt, k;
        bit first;
        bit [7:0] ts;
        poll = (interval == 0) ? PSHORT : PUNIT * interval;
        exp_n = 0; exp_cr = 0; exp_eq = 0;
        push(0, 0, 0, -1, "R2");
        push(1, 1, 0, 0, "R2");
        ts = 0;
        push(2, 0, ts, 0, "R2");
        prev = -1; cnt = 0; r = 0; first = 1;
        forever begin
            push(3, 0, 0, first ? SETTLE + poll : poll, first ? "R4" : "R5");
            first = 0; k = r; r++;
            if (!sc_ok[k]) break;
            if (sc_cr[k]) begin exp_cr = 1; break; end
            if (ts[2]) break;
            if (int'(ts[1:0]) == prev) begin
                cnt++;
                if (cnt >= 5) break;
            end else cnt = 0;
            prev = int'(ts[1:0]);
            ts = adj(sc_sw[k], sc_em[k]);
            push(2, 0, ts, 0, "R8");
        end
        push(1, 2, 0, 0, "R7");
        ecnt = 0;
        forever begin
            push(3, 0, 0, poll, "R5");
            k = r; r++;
            if (!sc_ok[k]) break;
            if (sc_eq[k]) begin exp_eq = 1; break; end
            if (ecnt > 5) break;
            ts = adj(sc_sw[k], sc_em[k]);
            push(2, 0, ts, 0, "R8");
            ecnt++;
        end
        push(0, 0, 0, SETTLE, "R12");
        push(4, 0, 0, 0, "R12");
        exp_final = ts;
    endtask

    // command responder
    initial begin
        bit just = 0;
        forever begin
            if (!just) @(negedge clk);
            just = 0;
            if (rst_n && cmd_req) begin
                int op, pat, dly;
                op = int'(cmd_op); pat = int'(cmd_pattern);
                if (act_n < CMAX) begin
                    act_op[act_n] = op; act_pat[act_n] = pat;
                    act_ts[act_n] = train_set; act_gap[act_n] = gapcnt;
                    act_n++;
                end
                dly = $urandom_range(0, 2);
                repeat (dly) begin
                    @(negedge clk);
                    check(cmd_req && int'(cmd_op) == op && int'(cmd_pattern) == pat,
                          "R3", "request held", int'(cmd_op), op);
                end
                if (op == 3) begin
                    int k;
                    k = (rd_idx < SLEN) ? rd_idx : SLEN - 1;
                    rd_idx++;
                    cmd_ok = sc_ok[k]; rsp_cr_done = sc_cr[k]; rsp_eq_done = sc_eq[k];
                    rsp_swing = sc_sw[k]; rsp_emph = sc_em[k];
                end
                cmd_ack = 1'b1;
                @(negedge clk);
                cmd_ack = 1'b0; cmd_ok = 1'b0; rsp_cr_done = 1'b0; rsp_eq_done = 1'b0;
                gapcnt = 0;
                just = 1;
            end else gapcnt++;
        end
    end

    task automatic fill(input bit ok, input bit cr, input bit eq,
                        input bit [1:0] sw, input bit [1:0] em);
        for (int i = 0; i < SLEN; i++) begin
            sc_ok[i] = ok; sc_cr[i] = cr; sc_eq[i] = eq; sc_sw[i] = sw; sc_em[i] = em;
        end
    endtask

    task automatic run_case(input string tag, input int interval);
        int wd;
        sc_ok[SLEN-4] = 0;
        model(interval);
        rd_interval = 8'(interval);
        act_n = 0; rd_idx = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wd = 0;
        while (!done && wd < 20000) begin @(negedge clk); wd++; end
        check(done == 1'b1, "R12", "done seen", int'(done), 1);
        check(cr_pass == exp_cr, tag, "cr_pass", int'(cr_pass), int'(exp_cr));
        check(eq_pass == exp_eq, tag, "eq_pass", int'(eq_pass), int'(exp_eq));
        check(act_n == exp_n, tag, "command count", act_n, exp_n);
        for (int i = 0; i < exp_n && i < act_n; i++) begin
            check(act_op[i] == exp_op[i], exp_tag[i], "op", act_op[i], exp_op[i]);
            if (exp_op[i] == 2)
                check(act_ts[i] == exp_ts[i], exp_tag[i], "drive value",
                      int'(act_ts[i]), int'(exp_ts[i]));
            else if (exp_op[i] != 3)
                check(act_pat[i] == exp_pat[i], exp_tag[i], "pattern", act_pat[i], exp_pat[i]);
            if (exp_gap[i] >= 0)
                check(act_gap[i] == exp_gap[i], exp_tag[i], "gap", act_gap[i], exp_gap[i]);
        end
        @(negedge clk);
        check(done == 1'b0, "R12", "done one cycle", int'(done), 0);
        check(train_set == exp_final, "R8", "final setting", int'(train_set), int'(exp_final));
    endtask

    initial begin
        #(4 * 190000);
        failures++;
        $display("FAIL watchdog R12 actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        check(cmd_req == 0 && done == 0, "R1", "reset req/done", int'(cmd_req), 0);
        check(cr_pass == 0 && eq_pass == 0, "R1", "reset pass", int'(cr_pass), 0);
        check(train_set == 8'd0, "R1", "reset setting", int'(train_set), 0);
        rst_n = 1'b1;

        fill(1, 0, 0, 2'd0, 2'd0); sc_cr[0] = 1; sc_eq[1] = 1;
        run_case("R7", 0);
        fill(1, 0, 0, 2'd1, 2'd1); sc_eq[8] = 1;
        run_case("R10", 1);
        fill(1, 0, 0, 2'd3, 2'd2);
        run_case("R9", 2);
        fill(1, 0, 0, 2'd0, 2'd0); sc_ok[0] = 0; sc_ok[1] = 0;
        run_case("R6", 0);
        fill(1, 0, 0, 2'd2, 2'd3); sc_cr[0] = 1;
        run_case("R11", 3);
        fill(1, 0, 0, 2'd0, 2'd1);
        for (int i = 3; i < 9; i++) sc_sw[i] = 2'd1;
        for (int i = 9; i < 20; i++) sc_sw[i] = 2'd2;
        run_case("R10", 0);

        for (int n = 0; n < 20; n++) begin
            for (int i = 0; i < SLEN; i++) begin
                sc_ok[i] = ($urandom % 16) != 0;
                sc_cr[i] = ($urandom % 6) == 0;
                sc_eq[i] = ($urandom % 5) == 0;
                sc_sw[i] = 2'($urandom % 4);
                sc_em[i] = 2'($urandom % 4);
            end
            run_case("R8", $urandom_range(0, 3));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule